// File: doc/BRIEF.md
# Sixteen-Channel DMA Register and Interrupt Hub

This block is the software-visible register file of a sixteen-channel DMA engine. Each channel owns a group of four 32-bit descriptor words: start address, row length, row count and control. It also owns a row-stride word. The channel datapaths read these words from flattened configuration buses. Software reaches all of it through a plain synchronous port: one write or one read per cycle, byte offsets, with read data returned one cycle after the request.

Alongside the descriptor storage the hub holds the shared control state. It decodes channel-stop strobes, collects one completion pulse per channel into sticky status flags and masks them with per-channel enables. A single interrupt line goes to the system. The hub also keeps a 32-bit loop-control word in which a channel repeats its buffer only while both of its paired bits are set. The enable word and the loop word each have a separate clear alias, so one channel can be changed without touching the others.

Top module: `dma_reg_hub`

## Requirements
- R1: After reset every descriptor word, stride word, status flag, enable flag and loop bit is zero, and `irq`, `ch_stop`, `loop_run` and `rdata` are all zero.
- R2: The word at offset ch*0x10 + 4*k (k = 0 address, 1 row length, 2 row count, 3 control) stores the written 32-bit value for channel ch. It reads back at that offset and appears on slice ch of `cfg_addr`, `cfg_xlen`, `cfg_ylen` or `cfg_ctrl`. Writes to one channel leave the others unchanged.
- R3: The stride word of channel ch lives at offset 0x100 + 4*ch. It reads back the written value and drives slice ch of `cfg_stride`.
- R4: A write to offset 0x140 raises `ch_stop[ch]` for exactly the one cycle after the write edge, for every channel whose bit ch of `wdata` is 1. At all other times `ch_stop` is zero.
- R5: A high `done_pulse[ch]` sets status flag ch, which reads as bit ch at offset 0x144. The flag stays set until a write to 0x144 with bit ch at 1. Writing 0 bits there has no effect.
- R6: When a completion pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: A write to 0x148 loads bits [15:0] into the enable flags, and bits [31:16] read as zero. A write to 0x14C clears each enable whose bit is 1 and leaves the rest.
- R8: `irq` is a registered OR over all channels of status AND enable. It rises one clock after the status flag it reflects, and falls one clock after the last enabled flag clears.
- R9: A write to 0x150 sets each loop bit written as 1, and a write to 0x15C clears each loop bit written as 1. `loop_run[ch]` is high only while loop bits ch and ch+16 are both set.
- R10: Reads of the write-only offsets 0x140, 0x14C and 0x15C, and of any unmapped offset, return zero.
- R11: `rdata` loads on the clock edge where `rd_en` is high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| rd_en | input | 1 | Read strobe for the register port |
| addr | input | 9 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| done_pulse | input | 16 | Per-channel completion strobes |
| irq | output | 1 | Combined interrupt |
| ch_stop | output | 16 | One-cycle per-channel stop strobes |
| loop_run | output | 16 | Per-channel loop mode active |
| cfg_addr | output | 512 | Start address words, 32 bits per channel |
| cfg_xlen | output | 512 | Row length words, 32 bits per channel |
| cfg_ylen | output | 512 | Row count words, 32 bits per channel |
| cfg_ctrl | output | 512 | Control words, 32 bits per channel |
| cfg_stride | output | 512 | Row stride words, 32 bits per channel |

## Verification
The properties assume that the port, the completion strobes and reset are the only things that change the hub's state. A status flag may rise only in the cycle after its strobe, loop pairs may become active only after a write to the set alias, and stop strobes may appear only after a write to the stop offset. They also assume that software issues reads and writes in separate cycles. The stimulus follows this: it drives every input at the falling edge, never raises `wr_en` and `rd_en` together, and uses word-aligned offsets. The one deliberate collision, a completion strobe in the same cycle as a clearing write, is applied only to test the set-priority rule.

// File: rtl/dma_hub_pkg.sv
package dma_hub_pkg;
  localparam int HUB_NCH = 16;
  localparam int HUB_DW  = 32;
  localparam int HUB_AW  = 9;
  localparam int HUB_CW  = $clog2(HUB_NCH);
  localparam int HUB_LW  = 2 * HUB_NCH;
  localparam int GRP_BYTES    = 16;
  localparam int STRIDE_BYTES = 4;

  localparam logic [HUB_AW-1:0] OFF_STRIDE   = 9'h100;
  localparam logic [HUB_AW-1:0] OFF_STOP     = 9'h140;
  localparam logic [HUB_AW-1:0] OFF_STAT     = 9'h144;
  localparam logic [HUB_AW-1:0] OFF_IEN      = 9'h148;
  localparam logic [HUB_AW-1:0] OFF_IEN_CLR  = 9'h14C;
  localparam logic [HUB_AW-1:0] OFF_LOOP     = 9'h150;
  localparam logic [HUB_AW-1:0] OFF_LOOP_CLR = 9'h15C;

  typedef enum logic [1:0] {
    FLD_ADDR = 2'd0,
    FLD_XLEN = 2'd1,
    FLD_YLEN = 2'd2,
    FLD_CTRL = 2'd3
  } chan_fld_e;

  typedef struct packed {
    logic              grp_hit;
    logic              str_hit;
    logic              stop_hit;
    logic              stat_hit;
    logic              ien_hit;
    logic              ien_clr_hit;
    logic              loop_hit;
    logic              loop_clr_hit;
    logic [HUB_CW-1:0] grp_ch;
    logic [HUB_CW-1:0] str_ch;
    chan_fld_e         fld;
  } hub_dec_t;

  function automatic hub_dec_t hub_decode(input logic [HUB_AW-1:0] a);
    hub_dec_t d;
    logic [HUB_AW-1:0] w;
    w = {a[HUB_AW-1:2], 2'b00};
    d = '0;
    d.grp_hit      = (int'(a) < HUB_NCH * GRP_BYTES);
    d.str_hit      = (w >= OFF_STRIDE) &&
                     (int'(w) < int'(OFF_STRIDE) + HUB_NCH * STRIDE_BYTES);
    d.stop_hit     = (w == OFF_STOP);
    d.stat_hit     = (w == OFF_STAT);
    d.ien_hit      = (w == OFF_IEN);
    d.ien_clr_hit  = (w == OFF_IEN_CLR);
    d.loop_hit     = (w == OFF_LOOP);
    d.loop_clr_hit = (w == OFF_LOOP_CLR);
    d.grp_ch       = a[4 +: HUB_CW];
    d.str_ch       = a[2 +: HUB_CW];
    d.fld          = chan_fld_e'(a[3:2]);
    return d;
  endfunction
endpackage

// File: rtl/hub_chan_regs.sv
module hub_chan_regs
  import dma_hub_pkg::*;
#(
  parameter int NCH = HUB_NCH,
  parameter int DW  = HUB_DW,
  parameter int CW  = HUB_CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grp_we,
  input  logic            str_we,
  input  logic [CW-1:0]   grp_ch,
  input  logic [CW-1:0]   str_ch,
  input  chan_fld_e       fld,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   grp_rdata,
  output logic [DW-1:0]   str_rdata,
  output logic [NCH*DW-1:0] addr_bus,
  output logic [NCH*DW-1:0] xlen_bus,
  output logic [NCH*DW-1:0] ylen_bus,
  output logic [NCH*DW-1:0] ctrl_bus,
  output logic [NCH*DW-1:0] str_bus
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          sel_g, sel_s;
    logic [DW-1:0] q_addr, q_xlen, q_ylen, q_ctrl, q_str;

    assign sel_g = grp_we && (grp_ch == CW'(i));
    assign sel_s = str_we && (str_ch == CW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_addr <= '0;
        q_xlen <= '0;
        q_ylen <= '0;
        q_ctrl <= '0;
        q_str  <= '0;
      end else begin
        if (sel_g && fld == FLD_ADDR) q_addr <= wdata;
        if (sel_g && fld == FLD_XLEN) q_xlen <= wdata;
        if (sel_g && fld == FLD_YLEN) q_ylen <= wdata;
        if (sel_g && fld == FLD_CTRL) q_ctrl <= wdata;
        if (sel_s)                    q_str  <= wdata;
      end
    end

    assign addr_bus[i*DW +: DW] = q_addr;
    assign xlen_bus[i*DW +: DW] = q_xlen;
    assign ylen_bus[i*DW +: DW] = q_ylen;
    assign ctrl_bus[i*DW +: DW] = q_ctrl;
    assign str_bus[i*DW +: DW]  = q_str;
  end

  always_comb begin
    case (fld)
      FLD_ADDR: grp_rdata = addr_bus[grp_ch*DW +: DW];
      FLD_XLEN: grp_rdata = xlen_bus[grp_ch*DW +: DW];
      FLD_YLEN: grp_rdata = ylen_bus[grp_ch*DW +: DW];
      default:  grp_rdata = ctrl_bus[grp_ch*DW +: DW];
    endcase
    str_rdata = str_bus[str_ch*DW +: DW];
  end
endmodule

// File: rtl/hub_irq_ctrl.sv
module hub_irq_ctrl
  import dma_hub_pkg::*;
#(
  parameter int NCH = HUB_NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] done,
  input  logic [NCH-1:0] stat_clr,
  input  logic           ien_ld,
  input  logic [NCH-1:0] ien_val,
  input  logic [NCH-1:0] ien_clr,
  output logic [NCH-1:0] stat_q,
  output logic [NCH-1:0] ien_q,
  output logic           irq
);
  logic [NCH-1:0] stat_d, ien_d;
  logic           irq_d;

  always_comb begin
    stat_d = (stat_q & ~stat_clr) | done;
    ien_d  = ien_ld ? ien_val : ien_q;
    ien_d  = ien_d & ~ien_clr;
    irq_d  = |(stat_q & ien_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ien_q  <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      ien_q  <= ien_d;
      irq    <= irq_d;
    end
  end
endmodule

// File: rtl/hub_loop_ctrl.sv
module hub_loop_ctrl
  import dma_hub_pkg::*;
#(
  parameter int NCH = HUB_NCH,
  parameter int LW  = 2 * NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [LW-1:0]  set_bits,
  input  logic [LW-1:0]  clr_bits,
  output logic [LW-1:0]  loop_q,
  output logic [NCH-1:0] run
);
  logic [LW-1:0] loop_d;

  always_comb loop_d = (loop_q & ~clr_bits) | set_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loop_q <= '0;
    else        loop_q <= loop_d;
  end

  assign run = loop_q[NCH-1:0] & loop_q[LW-1:NCH];
endmodule

// File: rtl/dma_reg_hub.sv
module dma_reg_hub
  import dma_hub_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [HUB_AW-1:0]         addr,
  input  logic [HUB_DW-1:0]         wdata,
  output logic [HUB_DW-1:0]         rdata,
  input  logic [HUB_NCH-1:0]        done_pulse,
  output logic                      irq,
  output logic [HUB_NCH-1:0]        ch_stop,
  output logic [HUB_NCH-1:0]        loop_run,
  output logic [HUB_NCH*HUB_DW-1:0] cfg_addr,
  output logic [HUB_NCH*HUB_DW-1:0] cfg_xlen,
  output logic [HUB_NCH*HUB_DW-1:0] cfg_ylen,
  output logic [HUB_NCH*HUB_DW-1:0] cfg_ctrl,
  output logic [HUB_NCH*HUB_DW-1:0] cfg_stride
);
  localparam int PADW = HUB_DW - HUB_NCH;

  hub_dec_t             dec;
  logic [HUB_DW-1:0]    grp_rdata, str_rdata, rd_mux, rdata_d;
  logic [HUB_NCH-1:0]   hub_stat, hub_ien, stop_d;
  logic [HUB_NCH-1:0]   stat_clr, ien_clr;
  logic [HUB_LW-1:0]    loop_word, loop_set, loop_clr;

  assign dec = hub_decode(addr);

  hub_chan_regs #(.NCH(HUB_NCH), .DW(HUB_DW), .CW(HUB_CW)) u_chan (
    .clk(clk), .rst_n(rst_n),
    .grp_we(wr_en && dec.grp_hit), .str_we(wr_en && dec.str_hit),
    .grp_ch(dec.grp_ch), .str_ch(dec.str_ch), .fld(dec.fld), .wdata(wdata),
    .grp_rdata(grp_rdata), .str_rdata(str_rdata),
    .addr_bus(cfg_addr), .xlen_bus(cfg_xlen), .ylen_bus(cfg_ylen),
    .ctrl_bus(cfg_ctrl), .str_bus(cfg_stride)
  );

  assign stat_clr = (wr_en && dec.stat_hit)    ? wdata[HUB_NCH-1:0] : '0;
  assign ien_clr  = (wr_en && dec.ien_clr_hit) ? wdata[HUB_NCH-1:0] : '0;

  hub_irq_ctrl #(.NCH(HUB_NCH)) u_irq (
    .clk(clk), .rst_n(rst_n), .done(done_pulse), .stat_clr(stat_clr),
    .ien_ld(wr_en && dec.ien_hit), .ien_val(wdata[HUB_NCH-1:0]),
    .ien_clr(ien_clr), .stat_q(hub_stat), .ien_q(hub_ien), .irq(irq)
  );

  assign loop_set = (wr_en && dec.loop_hit)     ? wdata[HUB_LW-1:0] : '0;
  assign loop_clr = (wr_en && dec.loop_clr_hit) ? wdata[HUB_LW-1:0] : '0;

  hub_loop_ctrl #(.NCH(HUB_NCH), .LW(HUB_LW)) u_loop (
    .clk(clk), .rst_n(rst_n), .set_bits(loop_set), .clr_bits(loop_clr),
    .loop_q(loop_word), .run(loop_run)
  );

  // stop strobes and read path: next-state logic
  always_comb begin
    stop_d = (wr_en && dec.stop_hit) ? wdata[HUB_NCH-1:0] : '0;
    rd_mux = '0;
    if (dec.grp_hit)       rd_mux = grp_rdata;
    else if (dec.str_hit)  rd_mux = str_rdata;
    else if (dec.stat_hit) rd_mux = {{PADW{1'b0}}, hub_stat};
    else if (dec.ien_hit)  rd_mux = {{PADW{1'b0}}, hub_ien};
    else if (dec.loop_hit) rd_mux = HUB_DW'(loop_word);
    rdata_d = rd_en ? rd_mux : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_stop <= '0;
      rdata   <= '0;
    end else begin
      ch_stop <= stop_d;
      rdata   <= rdata_d;
    end
  end
endmodule

// File: rtl/hub_checker.sv
module hub_checker
  import dma_hub_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                rd_en,
  input logic [HUB_AW-1:0]   addr,
  input logic [HUB_DW-1:0]   rdata,
  input logic [HUB_NCH-1:0]  done_pulse,
  input logic                irq,
  input logic [HUB_NCH-1:0]  ch_stop,
  input logic [HUB_NCH-1:0]  loop_run,
  input logic [HUB_NCH-1:0]  stat,
  input logic [HUB_NCH-1:0]  ien
);
  logic              armed;
  logic [HUB_AW-1:0] wa;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign wa = {addr[HUB_AW-1:2], 2'b00};

  // R4: stop strobes only follow a write to the stop offset
  p_stop_only_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(wr_en && wa == OFF_STOP) |-> ch_stop == '0);

  // R5: a flag rises only after its completion strobe
  p_stat_rise_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (stat & ~$past(stat) & ~$past(done_pulse)) == '0);

  // R5: flags hold unless the status offset was written
  p_stat_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(wr_en && wa == OFF_STAT) |-> ($past(stat) & ~stat) == '0);

  // R6: a strobe always leaves its flag set
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ($past(done_pulse) & ~stat) == '0);

  // R8: no interrupt without a pending flag and an enable
  p_irq_needs_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && irq |-> ($past(stat) != '0) && ($past(ien) != '0));

  // R9: loop activity starts only after a write to the set alias
  p_loop_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ((loop_run & ~$past(loop_run)) != '0) |-> $past(wr_en && wa == OFF_LOOP));

  // R9: loop activity stops only after a write to the clear alias
  p_loop_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed && (($past(loop_run) & ~loop_run) != '0) |-> $past(wr_en && wa == OFF_LOOP_CLR));

  // R11: read data holds between reads
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(rd_en) |-> $stable(rdata));
endmodule

bind dma_reg_hub hub_checker u_hub_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .done_pulse(done_pulse), .irq(irq), .ch_stop(ch_stop),
  .loop_run(loop_run), .stat(hub_stat), .ien(hub_ien)
);

// File: tb/sim_dma_reg_hub.sv
`timescale 1ns/1ps
module sim_dma_reg_hub;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en, rd_en;
  logic [8:0]   addr;
  logic [31:0]  wdata, rdata;
  logic [15:0]  done_pulse;
  logic         irq;
  logic [15:0]  ch_stop, loop_run;
  logic [511:0] cfg_addr, cfg_xlen, cfg_ylen, cfg_ctrl, cfg_stride;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  dma_reg_hub u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done_pulse(done_pulse), .irq(irq),
    .ch_stop(ch_stop), .loop_run(loop_run), .cfg_addr(cfg_addr),
    .cfg_xlen(cfg_xlen), .cfg_ylen(cfg_ylen), .cfg_ctrl(cfg_ctrl),
    .cfg_stride(cfg_stride)
  );

  // {offset, write value, expected read-back}
  localparam logic [72:0] VEC [10] = '{
    {9'h000, 32'h1000_0040, 32'h1000_0040},
    {9'h034, 32'h0000_00FF, 32'h0000_00FF},
    {9'h0F8, 32'h0000_0123, 32'h0000_0123},
    {9'h0AC, 32'h0000_0031, 32'h0000_0031},
    {9'h100, 32'h0000_0010, 32'h0000_0010},
    {9'h13C, 32'hABCD_0004, 32'hABCD_0004},
    {9'h148, 32'hFFFF_A5A5, 32'h0000_A5A5},
    {9'h14C, 32'h0000_0005, 32'h0000_0000},
    {9'h160, 32'hDEAD_BEEF, 32'h0000_0000},
    {9'h03C, 32'h0000_0010, 32'h0000_0010}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse_done(input logic [15:0] m);
    @(negedge clk);
    done_pulse = m;
    @(negedge clk);
    done_pulse = '0;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; done_pulse = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 ch_stop", {16'b0, ch_stop}, 32'h0);
    chk("R1 loop_run", {16'b0, loop_run}, 32'h0);
    chk("R1 cfg_ctrl ch9", cfg_ctrl[9*32 +: 32], 32'h0);
    do_read(9'h144, v); chk("R1 status", v, 32'h0);
    do_read(9'h150, v); chk("R1 loop word", v, 32'h0);

    // R2 R3 R7 R10: table walk
    for (int i = 0; i < 10; i++) begin
      do_write(VEC[i][72:64], VEC[i][63:32]);
      do_read(VEC[i][72:64], v);
      chk($sformatf("R2/R3/R7/R10 vec%0d", i), v, VEC[i][31:0]);
    end

    // R2: configuration buses and no aliasing between channels
    chk("R2 cfg_addr ch0", cfg_addr[0 +: 32], 32'h1000_0040);
    chk("R2 cfg_xlen ch3", cfg_xlen[3*32 +: 32], 32'h0000_00FF);
    chk("R2 cfg_ylen ch15", cfg_ylen[15*32 +: 32], 32'h0000_0123);
    chk("R2 cfg_ctrl ch10", cfg_ctrl[10*32 +: 32], 32'h0000_0031);
    do_read(9'h030, v); chk("R2 ch3 addr untouched", v, 32'h0);
    // R3: stride buses
    chk("R3 cfg_stride ch15", cfg_stride[15*32 +: 32], 32'hABCD_0004);
    chk("R3 cfg_stride ch0", cfg_stride[0 +: 32], 32'h0000_0010);
    // R7: clear alias removed bits 0 and 2 only
    do_read(9'h148, v); chk("R7 enable after clear alias", v, 32'h0000_A5A0);

    // R4: stop strobe lasts one cycle
    @(negedge clk);
    wr_en = 1'b1; addr = 9'h140; wdata = 32'h0000_8005;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4 stop strobe", {16'b0, ch_stop}, 32'h0000_8005);
    @(negedge clk);
    chk("R4 stop strobe ends", {16'b0, ch_stop}, 32'h0);
    do_read(9'h140, v); chk("R10 stop offset reads zero", v, 32'h0);

    // R5 R8: status and interrupt timing
    do_write(9'h148, 32'h0000_0004);
    @(negedge clk);
    done_pulse = 16'h0004;
    @(negedge clk);
    done_pulse = '0;
    chk("R8 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq raised", {31'b0, irq}, 32'h1);
    pulse_done(16'h0080);
    do_read(9'h144, v); chk("R5 status two flags", v, 32'h0000_0084);
    do_write(9'h144, 32'h0000_0000);
    do_read(9'h144, v); chk("R5 zero write keeps flags", v, 32'h0000_0084);
    do_write(9'h144, 32'h0000_0004);
    chk("R8 irq one cycle after clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R8 irq dropped", {31'b0, irq}, 32'h0);
    do_read(9'h144, v); chk("R5 only ch2 cleared", v, 32'h0000_0080);

    // R11: read data holds without rd_en
    held = v;
    do_write(9'h004, 32'h5555_AAAA);
    repeat (3) @(negedge clk);
    chk("R11 rdata held", rdata, held);

    // R6: set wins over clear
    @(negedge clk);
    wr_en = 1'b1; addr = 9'h144; wdata = 32'h0000_00A0; done_pulse = 16'h0020;
    @(negedge clk);
    wr_en = 1'b0; done_pulse = '0;
    do_read(9'h144, v); chk("R6 set beats clear", v, 32'h0000_0020);
    do_write(9'h144, 32'h0000_0020);
    do_read(9'h144, v); chk("R5 cleared", v, 32'h0);

    // R9: loop pairs
    do_write(9'h150, 32'h0001_0001);
    chk("R9 loop ch0 active", {16'b0, loop_run}, 32'h0000_0001);
    do_write(9'h150, 32'h0000_0002);
    chk("R9 single bit not active", {16'b0, loop_run}, 32'h0000_0001);
    do_read(9'h150, v); chk("R9 set alias ORs", v, 32'h0001_0003);
    do_write(9'h15C, 32'h0001_0000);
    chk("R9 clear pauses", {16'b0, loop_run}, 32'h0);
    do_read(9'h150, v); chk("R9 clear alias", v, 32'h0000_0003);
    do_read(9'h15C, v); chk("R10 loop clear reads zero", v, 32'h0);
    do_read(9'h1FC, v); chk("R10 unmapped reads zero", v, 32'h0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule